// File: doc/BRIEF.md
# I2C Bus Timing and Timeout Timer

This block is a machine-cycle timer that serves an I2C controller. It has two jobs. First, it times the minimum interval the controller must leave between bus events, and signals the end of that interval with a one-cycle strobe. Second, it detects a bus that has stopped moving and raises a sticky timeout flag, which can request an interrupt. The timer advances only on a machine-cycle tick. An external divide-by-12 prescaler supplies that tick as a single-cycle enable.

Two inputs choose the operating mode: the OR of the three I2C enables (slave enable, master request, master active) and a run control. The mode is held in a registered four-state machine:
- `MD_HELD`: all enables low, run low. The counter is cleared.
- `MD_FREE`: all enables low, run high. The counter is a free-running time base.
- `MD_LOW`: an enable high, run low. Only the low three bits count, which gives minimum-time generation with no hang check.
- `MD_BUS`: an enable high, run high. The whole counter runs, and SCL edges, START and STOP clear it.

From any state the machine moves on the next clock to the state that matches the inputs. The transitions are named after their targets: hold, free, low-only and bus. Reset enters `MD_HELD`.

A two-bit select sets both the minimum count and the timeout length. Both grow together as the select steps through the order 11, 00, 01, 10.

Top module: `i2c_tmo_timer`

## Requirements
- R1: After reset, and while the registered mode is `MD_HELD` (mode inputs all low), `time_count` reads 0 and `min_done` stays low.
- R2: In `MD_FREE`, `time_count` increments by one on each `tick`. A tick at 1023 wraps it to 0 and sets `ovf_flag`.
- R3: In `MD_LOW`, bits [9:3] of `time_count` read 0. Bits [2:0] count ticks only until the minimum is reached, and `ovf_flag` never sets from counting.
- R4: In `MD_BUS`, `time_count` increments on each tick. Any of `scl_edge`, `start_det` or `stop_det` clears it to 0 and re-arms the minimum strobe. A clear wins over a tick in the same cycle.
- R5: `min_done` is a single-cycle pulse. It is produced by the tick that brings the count since the last clear (or since reset or `MD_HELD`) to the minimum, and it fires once per clear. The minimum is 7 for `tsel`=2'b10, 6 for 2'b01, 5 for 2'b00 and 4 for 2'b11.
- R6: In `MD_BUS`, the tick that would bring `time_count` to the timeout sets `ovf_flag` and returns the count to 0. The timeout is 1023 for `tsel`=2'b10, 1022 for 2'b01, 1021 for 2'b00 and 1020 for 2'b11.
- R7: `ovf_flag` stays set until a cycle with `ovf_clr` high. If a new overflow arrives in the same cycle as the clear, the flag stays set.
- R8: `ovf_irq` equals `ovf_flag` AND `ovf_irq_en`. The enable has no effect on `ovf_flag`.
- R9: A change on the mode inputs takes effect on the counter one clock later, through the registered mode.
- R10: Without `tick` the count does not advance. Bus event pulses have no effect in `MD_HELD` and `MD_FREE`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Machine-cycle enable (oscillator/12), one clock wide |
| slv_en | input | 1 | Slave enable |
| mst_req | input | 1 | Master request |
| mst_act | input | 1 | Master active status |
| run | input | 1 | Timer run control |
| tsel | input | 2 | Timing select code |
| scl_edge | input | 1 | SCL transition detected pulse |
| start_det | input | 1 | START condition detected pulse |
| stop_det | input | 1 | STOP condition detected pulse |
| ovf_irq_en | input | 1 | Overflow interrupt enable |
| ovf_clr | input | 1 | Clear for the overflow flag |
| time_count | output | 10 | Current timer value |
| min_done | output | 1 | Minimum-time elapsed strobe |
| ovf_flag | output | 1 | Sticky timeout/overflow flag |
| ovf_irq | output | 1 | Gated overflow interrupt request |

## Verification
The hardest case to reach is a timeout that lands in the same clock as a software clear. It needs more than a thousand uninterrupted ticks in bus mode, followed by exact alignment with `ovf_clr`. The stimulus holds `ovf_clr` high for a whole bus-mode window, so whichever cycle the overflow falls in, it coincides with a clear. The bench repeats this for every select code. The minimum strobe under sparse ticks, and under mode changes partway through a count, are reached by slowing the tick generator to one tick in three and by switching modes while bus events are still arriving.

// File: rtl/i2c_tmo_pkg.sv
package i2c_tmo_pkg;

    typedef enum logic [1:0] {
        MD_HELD = 2'b00,
        MD_FREE = 2'b01,
        MD_LOW  = 2'b10,
        MD_BUS  = 2'b11
    } tmr_mode_e;

    // Rank of a select code in ascending length order: 11,00,01,10 -> 0..3
    function automatic logic [1:0] sel_rank(input logic [1:0] sel);
        return sel + 2'd1;
    endfunction

endpackage

// File: rtl/i2c_tmo_mode_fsm.sv
module i2c_tmo_mode_fsm
    import i2c_tmo_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      slv_en,
    input  logic      mst_req,
    input  logic      mst_act,
    input  logic      run,
    output tmr_mode_e mode_q,
    output logic      ctl_hold,
    output logic      ctl_free,
    output logic      ctl_low,
    output logic      ctl_bus
);

    logic      any_en;
    tmr_mode_e mode_d;

    assign any_en = slv_en | mst_req | mst_act;

    // Next-state: every state goes to the one the inputs select
    always_comb begin
        unique case ({any_en, run})
            2'b00: mode_d = MD_HELD;
            2'b01: mode_d = MD_FREE;
            2'b10: mode_d = MD_LOW;
            2'b11: mode_d = MD_BUS;
            default: mode_d = MD_HELD;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) mode_q <= MD_HELD;
        else        mode_q <= mode_d;
    end

    // Output decode
    always_comb begin
        ctl_hold = 1'b0;
        ctl_free = 1'b0;
        ctl_low  = 1'b0;
        ctl_bus  = 1'b0;
        unique case (mode_q)
            MD_HELD: ctl_hold = 1'b1;
            MD_FREE: ctl_free = 1'b1;
            MD_LOW:  ctl_low  = 1'b1;
            MD_BUS:  ctl_bus  = 1'b1;
            default: ctl_hold = 1'b1;
        endcase
    end

    // R9
    mode_bus_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (any_en && run) |=> ctl_bus);
    // R9
    mode_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!any_en && !run) |=> ctl_hold);

endmodule

// File: rtl/i2c_tmo_counter.sv
module i2c_tmo_counter
    import i2c_tmo_pkg::*;
#(
    parameter int CNT_W = 10,
    parameter int LOW_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             ctl_hold,
    input  logic             ctl_free,
    input  logic             ctl_low,
    input  logic             ctl_bus,
    input  logic [1:0]       tsel,
    input  logic             bus_evt,
    output logic [CNT_W-1:0] cnt_q,
    output logic             min_done_q,
    output logic             ovf_pulse
);

    localparam int HI_W    = CNT_W - LOW_W;
    localparam int LOW_MAX = (1 << LOW_W) - 1;
    localparam int CNT_MAX = (1 << CNT_W) - 1;

    logic [1:0]       rank;
    logic [LOW_W-1:0] min_low;
    logic [CNT_W-1:0] min_full_m1;
    logic [CNT_W-1:0] tmo_m1;
    logic [LOW_W-1:0] low_inc;
    logic [CNT_W-1:0] cnt_d;
    logic             armed_q, armed_d;
    logic             strobe_d;

    assign rank        = sel_rank(tsel);
    assign min_low     = LOW_W'(LOW_MAX - 3) + LOW_W'(rank);
    assign min_full_m1 = {{HI_W{1'b0}}, min_low} - CNT_W'(1);
    assign tmo_m1      = CNT_W'(CNT_MAX - 4) + CNT_W'(rank);
    assign low_inc     = cnt_q[LOW_W-1:0] + LOW_W'(1);

    always_comb begin
        cnt_d     = cnt_q;
        armed_d   = armed_q;
        strobe_d  = 1'b0;
        ovf_pulse = 1'b0;
        if (ctl_hold) begin
            cnt_d   = '0;
            armed_d = 1'b1;
        end else if (ctl_free) begin
            armed_d = 1'b1;
            if (tick) begin
                cnt_d = cnt_q + CNT_W'(1);
                if (cnt_q == CNT_W'(CNT_MAX)) ovf_pulse = 1'b1;
            end
        end else if (ctl_low) begin
            cnt_d[CNT_W-1:LOW_W] = '0;
            if (bus_evt) begin
                cnt_d   = '0;
                armed_d = 1'b1;
            end else if (tick && armed_q) begin
                cnt_d[LOW_W-1:0] = low_inc;
                if (low_inc == min_low) begin
                    strobe_d = 1'b1;
                    armed_d  = 1'b0;
                end
            end
        end else if (ctl_bus) begin
            if (bus_evt) begin
                cnt_d   = '0;
                armed_d = 1'b1;
            end else if (tick) begin
                if (armed_q && cnt_q == min_full_m1) begin
                    strobe_d = 1'b1;
                    armed_d  = 1'b0;
                end
                if (cnt_q == tmo_m1) begin
                    cnt_d     = '0;
                    ovf_pulse = 1'b1;
                end else begin
                    cnt_d = cnt_q + CNT_W'(1);
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q      <= '0;
            armed_q    <= 1'b1;
            min_done_q <= 1'b0;
        end else begin
            cnt_q      <= cnt_d;
            armed_q    <= armed_d;
            min_done_q <= strobe_d;
        end
    end

    // R1
    held_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_hold |=> (cnt_q == '0 && !min_done_q));
    // R3
    low_hi_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_low |=> (cnt_q[CNT_W-1:LOW_W] == '0));
    // R4
    evt_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_bus && bus_evt) |=> (cnt_q == '0));
    // R5
    strobe_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        min_done_q |=> !min_done_q);
    // R10
    no_tick_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && ctl_free) |=> $stable(cnt_q));

endmodule

// File: rtl/i2c_tmo_flag.sv
module i2c_tmo_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic ovf_set,
    input  logic ovf_clr,
    input  logic irq_en,
    output logic flag_q,
    output logic irq
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       flag_q <= 1'b0;
        else if (ovf_set) flag_q <= 1'b1;
        else if (ovf_clr) flag_q <= 1'b0;
    end

    assign irq = flag_q & irq_en;

    // R7
    flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_q && !ovf_clr) |=> flag_q);
    // R7
    set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_set |=> flag_q);
    // R8
    irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (flag_q && irq_en));

endmodule

// File: rtl/i2c_tmo_timer.sv
module i2c_tmo_timer
    import i2c_tmo_pkg::*;
#(
    parameter int CNT_W = 10,
    parameter int LOW_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             slv_en,
    input  logic             mst_req,
    input  logic             mst_act,
    input  logic             run,
    input  logic [1:0]       tsel,
    input  logic             scl_edge,
    input  logic             start_det,
    input  logic             stop_det,
    input  logic             ovf_irq_en,
    input  logic             ovf_clr,
    output logic [CNT_W-1:0] time_count,
    output logic             min_done,
    output logic             ovf_flag,
    output logic             ovf_irq
);

    tmr_mode_e mode_q;
    logic      ctl_hold, ctl_free, ctl_low, ctl_bus;
    logic      bus_evt;
    logic      ovf_pulse;

    assign bus_evt = scl_edge | start_det | stop_det;

    i2c_tmo_mode_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .slv_en   (slv_en),
        .mst_req  (mst_req),
        .mst_act  (mst_act),
        .run      (run),
        .mode_q   (mode_q),
        .ctl_hold (ctl_hold),
        .ctl_free (ctl_free),
        .ctl_low  (ctl_low),
        .ctl_bus  (ctl_bus)
    );

    i2c_tmo_counter #(.CNT_W(CNT_W), .LOW_W(LOW_W)) u_cnt (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick       (tick),
        .ctl_hold   (ctl_hold),
        .ctl_free   (ctl_free),
        .ctl_low    (ctl_low),
        .ctl_bus    (ctl_bus),
        .tsel       (tsel),
        .bus_evt    (bus_evt),
        .cnt_q      (time_count),
        .min_done_q (min_done),
        .ovf_pulse  (ovf_pulse)
    );

    i2c_tmo_flag u_flag (
        .clk     (clk),
        .rst_n   (rst_n),
        .ovf_set (ovf_pulse),
        .ovf_clr (ovf_clr),
        .irq_en  (ovf_irq_en),
        .flag_q  (ovf_flag),
        .irq     (ovf_irq)
    );

    // R3
    low_no_ovf_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == MD_LOW && !ovf_flag && !ovf_clr) |=> !ovf_flag);
    // R10
    held_evt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == MD_HELD) |=> !min_done);

endmodule

// File: tb/i2c_tmo_timer_tb.sv
`timescale 1ns/1ps
module i2c_tmo_timer_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick = 1'b0;
    logic       slv_en = 1'b0, mst_req = 1'b0, mst_act = 1'b0, run = 1'b0;
    logic [1:0] tsel = 2'b00;
    logic       scl_edge = 1'b0, start_det = 1'b0, stop_det = 1'b0;
    logic       ovf_irq_en = 1'b0, ovf_clr = 1'b0;
    logic [9:0] time_count;
    logic       min_done, ovf_flag, ovf_irq;

    int compared = 0;
    int mismatched = 0;
    int tick_div = 1;
    int tick_ph = 0;
    int cyc = 0;
    bit checking = 1'b0;

    // Reference state
    int m_mode, m_cnt, m_arm;
    bit m_str, m_flag;

    always #2.5 clk = ~clk;

    i2c_tmo_timer u_dut (
        .clk(clk), .rst_n(rst_n), .tick(tick),
        .slv_en(slv_en), .mst_req(mst_req), .mst_act(mst_act), .run(run),
        .tsel(tsel), .scl_edge(scl_edge), .start_det(start_det), .stop_det(stop_det),
        .ovf_irq_en(ovf_irq_en), .ovf_clr(ovf_clr),
        .time_count(time_count), .min_done(min_done), .ovf_flag(ovf_flag), .ovf_irq(ovf_irq)
    );

    // Behavioural reference model
    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_mode = 0; m_cnt = 0; m_arm = 1; m_str = 0; m_flag = 0;
        end else begin
            int rk, mn, tm;
            bit evt, setf;
            rk = (int'(tsel) + 1) % 4;
            mn = 4 + rk;
            tm = 1020 + rk;
            evt = scl_edge || start_det || stop_det;
            m_str = 0; setf = 0;
            case (m_mode)
                0: begin m_cnt = 0; m_arm = 1; end
                1: begin
                    m_arm = 1;
                    if (tick) begin
                        if (m_cnt == 1023) begin m_cnt = 0; setf = 1; end
                        else m_cnt = m_cnt + 1;
                    end
                end
                2: begin
                    m_cnt = m_cnt % 8;
                    if (evt) begin m_cnt = 0; m_arm = 1; end
                    else if (tick && m_arm == 1) begin
                        m_cnt = (m_cnt + 1) % 8;
                        if (m_cnt == mn) begin m_str = 1; m_arm = 0; end
                    end
                end
                default: begin
                    if (evt) begin m_cnt = 0; m_arm = 1; end
                    else if (tick) begin
                        if (m_arm == 1 && m_cnt == mn - 1) begin m_str = 1; m_arm = 0; end
                        if (m_cnt == tm - 1) begin m_cnt = 0; setf = 1; end
                        else m_cnt = (m_cnt + 1) % 1024;
                    end
                end
            endcase
            if (setf) m_flag = 1;
            else if (ovf_clr) m_flag = 0;
            m_mode = ((slv_en || mst_req || mst_act) ? 2 : 0) + (run ? 1 : 0);
        end
    end

    function automatic string cnt_tag(int md);
        case (md)
            0: return "R1";
            1: return "R2";
            2: return "R3";
            default: return "R4";
        endcase
    endfunction

    // Compare on every clock, away from the active edge
    always @(negedge clk) begin
        cyc++;
        if (checking) begin
            compared++;
            if (int'(time_count) != m_cnt) begin
                mismatched++;
                $display("FAIL %s/R9/R10 time_count actual=%0d expected=%0d t=%0t",
                         cnt_tag(m_mode), time_count, m_cnt, $time);
            end
            compared++;
            if (min_done != m_str) begin
                mismatched++;
                $display("FAIL R5 min_done actual=%0b expected=%0b t=%0t", min_done, m_str, $time);
            end
            compared++;
            if (ovf_flag != m_flag) begin
                mismatched++;
                $display("FAIL R6/R7 ovf_flag actual=%0b expected=%0b t=%0t", ovf_flag, m_flag, $time);
            end
            compared++;
            if (ovf_irq != (m_flag && ovf_irq_en)) begin
                mismatched++;
                $display("FAIL R8 ovf_irq actual=%0b expected=%0b t=%0t",
                         ovf_irq, m_flag && ovf_irq_en, $time);
            end
        end
        if (cyc > 150000) begin
            mismatched++;
            $display("FAIL watchdog expired actual=%0d expected<=150000 cycles", cyc);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

    // Machine-cycle tick generator
    always @(negedge clk) begin
        #1;
        tick = (tick_ph == 0);
        tick_ph = (tick_ph + 1) % tick_div;
    end

    task automatic wait_cyc(int n);
        repeat (n) @(negedge clk);
        #1;
    endtask

    task automatic set_mode(bit en, bit r);
        @(negedge clk); #1;
        slv_en = en; mst_req = 1'b0; mst_act = 1'b0; run = r;
    endtask

    task automatic pulse(int which);
        @(negedge clk); #1;
        case (which)
            0: scl_edge = 1'b1;
            1: start_det = 1'b1;
            default: stop_det = 1'b1;
        endcase
        @(negedge clk); #1;
        scl_edge = 1'b0; start_det = 1'b0; stop_det = 1'b0;
    endtask

    task automatic clr_flag();
        @(negedge clk); #1; ovf_clr = 1'b1;
        @(negedge clk); #1; ovf_clr = 1'b0;
    endtask

    initial begin
        wait_cyc(3);
        rst_n = 1'b1;
        checking = 1'b1;
        // R1 reset state; R10 events ignored while held
        wait_cyc(5);
        pulse(0); pulse(1); pulse(2);
        wait_cyc(5);

        // R2 free run with wrap and flag; R8 gating with enable off then on
        set_mode(1'b0, 1'b1);
        wait_cyc(1100);
        ovf_irq_en = 1'b1;
        wait_cyc(5);
        pulse(0);                 // R10 event ignored in free mode
        clr_flag();               // R7
        ovf_irq_en = 1'b0;
        wait_cyc(5);

        for (int s = 0; s < 4; s++) begin
            tsel = 2'(s);
            // R3/R5 low-only minimum timing
            set_mode(1'b0, 1'b0);
            wait_cyc(2);
            @(negedge clk); #1; mst_req = 1'b0; slv_en = 1'b1; run = 1'b0;
            wait_cyc(15);
            pulse(s % 3);
            wait_cyc(15);
            // R4/R5/R6 bus mode with periodic SCL edges, then a timeout
            @(negedge clk); #1; run = 1'b1;
            for (int k = 0; k < 6; k++) begin
                wait_cyc(3 + k * 2);
                pulse(k % 3);
            end
            ovf_irq_en = (s % 2 == 1);
            wait_cyc(1100);
            clr_flag();
            // R7 timeout landing on a held clear
            @(negedge clk); #1; ovf_clr = 1'b1;
            pulse(1);
            wait_cyc(1060);
            @(negedge clk); #1; ovf_clr = 1'b0;
            wait_cyc(3);
        end

        // R10 sparse ticks; R9 mode switches mid-count
        tick_div = 3;
        tsel = 2'b10;
        set_mode(1'b1, 1'b1);
        pulse(0);
        wait_cyc(10);
        set_mode(1'b1, 1'b0);
        wait_cyc(12);
        set_mode(1'b0, 1'b1);
        wait_cyc(9);
        set_mode(1'b1, 1'b1);
        wait_cyc(7);
        pulse(2);
        wait_cyc(30);
        set_mode(1'b0, 1'b0);
        wait_cyc(5);
        tick_div = 1;
        @(negedge clk); #1; mst_act = 1'b1; run = 1'b1;
        wait_cyc(20);
        @(negedge clk); #1; mst_act = 1'b0; run = 1'b0;
        wait_cyc(5);

        checking = 1'b0;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

endmodule